// File: doc/BRIEF.md
# Integer to Floating-Point Converter

This block turns an integer held in a 64-bit register value into an IEEE 754 binary floating-point value. The integer may be a signed or unsigned 32-bit quantity (taken from the low half of the operand) or a signed or unsigned 64-bit quantity. The target is either double precision, or single precision that is then written out in its double-precision encoding so that it can sit in a 64-bit floating-point register.

Alongside the value the block produces a five-bit class code for the result, a flag saying the rounded significand was incremented, a flag saying the result is not exact, and a sticky inexact flag that accumulates until reset. A flag-update enable tells the surrounding status logic whether this conversion may touch status at all. A 32-bit integer going to double is always exact, so for that case the enable is low and every flag is left alone.

The path is one registered stage: an input strobe with its operands gives a registered result and an output valid one clock later.

Top module: `int2fp_conv`

## Requirements
- R1: The type code selects the source: 0 signed 32-bit, 1 unsigned 32-bit, 2 signed 64-bit, 3 unsigned 64-bit. For the 32-bit codes, operand bits 63:32 have no effect.
- R2: When the precision select is 0 (double) and the type code is 0 or 1, the flag-update enable is 0, both fraction flags are 0 and the sticky flag keeps its value. In all other cases the enable is 1.
- R3: A conversion that needs rounding uses the mode input: 00 nearest with ties to even, 01 toward zero, 10 toward plus infinity, 11 toward minus infinity.
- R4: When flags are updated, the fraction-inexact flag is 1 exactly when the result differs from the integer, and the fraction-rounded flag is 1 exactly when rounding raised the significand magnitude. A rounded result is always also inexact.
- R5: The sticky inexact flag becomes 1 on any flag-updating conversion that is inexact and stays 1 until reset.
- R6: With the precision select at 1, the value is rounded to a 24-bit significand and returned as the double encoding of that single value, so result bits 28:0 are always 0.
- R7: The class code is 00100 for a positive normal result, 01000 for a negative normal result and 00010 for plus zero.
- R8: A zero integer gives +0.0 (all 64 result bits 0) in every rounding mode and precision.
- R9: Unsigned 64-bit all ones gives 2^64 (0x43F0000000000000) when rounded to nearest and 2^64-2048 (0x43EFFFFFFFFFFFFF) toward zero; signed 64-bit 0x8000000000000000 gives exactly -2^63 (0xC3E0000000000000).
- R10: Outputs change only on the clock edge after an input strobe; output valid is the input strobe delayed by one cycle, and without a strobe the result, class and flags hold.
- R11: Reset drives output valid, result, class, all flags and the sticky flag to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input strobe; operands are taken on this cycle |
| in_operand | input | 64 | Integer operand register value |
| in_int_type | input | 2 | Integer type code |
| in_single | input | 1 | 1 = single-precision target, 0 = double |
| in_rmode | input | 2 | Rounding mode |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| out_result | output | 64 | Floating-point result in double encoding |
| out_class | output | 5 | Result class code |
| out_frac_rounded | output | 1 | Rounding incremented the significand |
| out_frac_inexact | output | 1 | Result is not exact |
| out_inexact_sticky | output | 1 | Accumulated inexact flag |
| out_flag_update | output | 1 | Status may be updated by this conversion |

## Verification
The hardest outcomes to reach are the exact halfway ties and the rounding carry that ripples out of the significand into the exponent, because they need integers whose dropped bits form exactly one half or whose kept bits are all ones. The stimulus builds these directly: 2^24+1 and 2^53+1 and 2^53+3 give ties with even and odd kept bits, and all-ones 64-bit and 32-bit operands force the carry, each run under the directed rounding modes so that sign-dependent directions differ. The sticky flag's hold is shown by running exact conversions after an inexact one and again after a reset.

// File: rtl/int2fp_pkg.sv
package int2fp_pkg;

   localparam int INT_W   = 64;
   localparam int EXP_W   = 11;
   localparam int FRAC_W  = 52;
   localparam int BIAS    = 1023;
   localparam int DBL_MAN = 53;
   localparam int SGL_MAN = 24;

   // rounding direction codes as seen on the mode input
   localparam logic [1:0] RM_NEAR = 2'b00;
   localparam logic [1:0] RM_ZERO = 2'b01;
   localparam logic [1:0] RM_UP   = 2'b10;
   localparam logic [1:0] RM_DOWN = 2'b11;

   // result class codes
   localparam logic [4:0] CLS_POS_NORM = 5'b00100;
   localparam logic [4:0] CLS_NEG_NORM = 5'b01000;
   localparam logic [4:0] CLS_POS_ZERO = 5'b00010;

endpackage

// File: rtl/int2fp_operand_prep.sv
// Splits the operand into a sign and an unsigned magnitude for the selected type.
module int2fp_operand_prep #(
   parameter int INT_W = 64
) (
   input  logic [INT_W-1:0] operand,
   input  logic [1:0]       int_type,
   output logic             sign,
   output logic [INT_W-1:0] mag
);
   localparam int HALF_W = INT_W / 2;

   logic             wide;
   logic             unsgn;
   logic [HALF_W-1:0] lo;
   logic [HALF_W-1:0] lo_mag;
   logic [INT_W-1:0]  full_mag;

   assign wide  = int_type[1];
   assign unsgn = int_type[0];
   assign lo    = operand[HALF_W-1:0];

   always_comb begin
      if (wide) sign = !unsgn && operand[INT_W-1];
      else      sign = !unsgn && lo[HALF_W-1];
      lo_mag   = sign ? (~lo + 1'b1) : lo;
      full_mag = sign ? (~operand + 1'b1) : operand;
      mag      = wide ? full_mag : {{HALF_W{1'b0}}, lo_mag};
   end

endmodule

// File: rtl/int2fp_normalize.sv
// Leading-zero count and left shift so the top set bit lands in the MSB.
module int2fp_normalize #(
   parameter int INT_W = 64,
   localparam int LZ_W = $clog2(INT_W) + 1
) (
   input  logic [INT_W-1:0] mag,
   output logic [INT_W-1:0] norm,
   output logic [LZ_W-1:0]  lz,
   output logic             is_zero
);

   always_comb begin
      lz = LZ_W'(INT_W);
      for (int b = 0; b < INT_W; b++) begin
         if (mag[b]) lz = LZ_W'(INT_W - 1 - b);
      end
      is_zero = (mag == '0);
      norm    = mag << lz;
   end

endmodule

// File: rtl/int2fp_round.sv
// Rounds a normalized magnitude to MAN_W significand bits and returns the
// fraction left-aligned in a FRAC_W field.
module int2fp_round #(
   parameter int INT_W  = 64,
   parameter int MAN_W  = 53,
   parameter int FRAC_W = 52
) (
   input  logic [INT_W-1:0]  norm,
   input  logic              sign,
   input  logic [1:0]        rmode,
   output logic [FRAC_W-1:0] frac,
   output logic              carry,
   output logic              inexact,
   output logic              incr
);
   import int2fp_pkg::*;

   localparam int DROP = INT_W - MAN_W;
   localparam int PAD  = FRAC_W - (MAN_W - 1);

   logic [MAN_W-1:0] keep;
   logic             guard;
   logic             sticky;
   logic [MAN_W:0]   sum;

   assign keep    = norm[INT_W-1 -: MAN_W];
   assign guard   = norm[DROP-1];
   assign sticky  = |norm[DROP-2:0];
   assign inexact = guard | sticky;

   always_comb begin
      unique case (rmode)
         RM_NEAR: incr = guard && (sticky || keep[0]);
         RM_ZERO: incr = 1'b0;
         RM_UP:   incr = inexact && !sign;
         default: incr = inexact && sign;
      endcase
      sum   = {1'b0, keep} + {{MAN_W{1'b0}}, incr};
      carry = sum[MAN_W];
      // after a carry the kept bits are all zero, so the fraction is zero too
      frac  = FRAC_W'(sum[MAN_W-2:0]) << PAD;
   end

endmodule

// File: rtl/int2fp_conv.sv
module int2fp_conv #(
   parameter int INT_W   = int2fp_pkg::INT_W,
   parameter int EXP_W   = int2fp_pkg::EXP_W,
   parameter int FRAC_W  = int2fp_pkg::FRAC_W,
   parameter int BIAS    = int2fp_pkg::BIAS,
   parameter int DBL_MAN = int2fp_pkg::DBL_MAN,
   parameter int SGL_MAN = int2fp_pkg::SGL_MAN
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [INT_W-1:0]  in_operand,
   input  logic [1:0]        in_int_type,
   input  logic              in_single,
   input  logic [1:0]        in_rmode,
   output logic              out_valid,
   output logic [INT_W-1:0]  out_result,
   output logic [4:0]        out_class,
   output logic              out_frac_rounded,
   output logic              out_frac_inexact,
   output logic              out_inexact_sticky,
   output logic              out_flag_update
);
   import int2fp_pkg::*;

   localparam int LZ_W = $clog2(INT_W) + 1;
   localparam int RES_W = 1 + EXP_W + FRAC_W;
   localparam logic [EXP_W-1:0] E_TOP = EXP_W'(BIAS + INT_W - 1);

   // elaboration checks on the parameter set
   if (SGL_MAN >= DBL_MAN || DBL_MAN + 2 > INT_W || RES_W != INT_W
       || DBL_MAN - 1 > FRAC_W) begin : g_bad_params
      $error("int2fp_conv: inconsistent width parameters");
   end

   logic             sgn;
   logic [INT_W-1:0] mag;
   logic [INT_W-1:0] norm;
   logic [LZ_W-1:0]  lz;
   logic             is_zero;

   int2fp_operand_prep #(.INT_W(INT_W)) u_prep (
      .operand  (in_operand),
      .int_type (in_int_type),
      .sign     (sgn),
      .mag      (mag)
   );

   int2fp_normalize #(.INT_W(INT_W)) u_norm (
      .mag     (mag),
      .norm    (norm),
      .lz      (lz),
      .is_zero (is_zero)
   );

   // one rounder per target precision: index 0 double, index 1 single
   logic [FRAC_W-1:0] p_frac [2];
   logic              p_carry [2];
   logic              p_inexact [2];
   logic              p_incr [2];

   for (genvar p = 0; p < 2; p++) begin : g_prec
      localparam int MAN = (p == 0) ? DBL_MAN : SGL_MAN;
      int2fp_round #(.INT_W(INT_W), .MAN_W(MAN), .FRAC_W(FRAC_W)) u_rnd (
         .norm    (norm),
         .sign    (sgn),
         .rmode   (in_rmode),
         .frac    (p_frac[p]),
         .carry   (p_carry[p]),
         .inexact (p_inexact[p]),
         .incr    (p_incr[p])
      );
   end

   logic              quiet;
   logic [FRAC_W-1:0] sel_frac;
   logic              sel_carry;
   logic              sel_inexact;
   logic              sel_incr;
   logic [EXP_W-1:0]  exp_b;
   logic [INT_W-1:0]  nxt_result;
   logic [4:0]        nxt_class;

   always_comb begin
      quiet       = !in_single && !in_int_type[1];
      sel_frac    = in_single ? p_frac[1]    : p_frac[0];
      sel_carry   = in_single ? p_carry[1]   : p_carry[0];
      sel_inexact = in_single ? p_inexact[1] : p_inexact[0];
      sel_incr    = in_single ? p_incr[1]    : p_incr[0];
      exp_b       = E_TOP - EXP_W'(lz) + EXP_W'(sel_carry);
      if (is_zero) begin
         nxt_result = '0;
         nxt_class  = CLS_POS_ZERO;
      end else begin
         nxt_result = {sgn, exp_b, sel_frac};
         nxt_class  = sgn ? CLS_NEG_NORM : CLS_POS_NORM;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid          <= 1'b0;
         out_result         <= '0;
         out_class          <= '0;
         out_frac_rounded   <= 1'b0;
         out_frac_inexact   <= 1'b0;
         out_inexact_sticky <= 1'b0;
         out_flag_update    <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_result       <= nxt_result;
            out_class        <= nxt_class;
            out_flag_update  <= !quiet;
            out_frac_rounded <= !quiet && sel_incr;
            out_frac_inexact <= !quiet && sel_inexact;
            if (!quiet && sel_inexact) out_inexact_sticky <= 1'b1;
         end
      end
   end

   // ---------------- assertions ----------------
   always_comb begin
      if (rst_n && in_single === 1'b1) begin
         assert_single_lsbs_R6: assert (nxt_result[28:0] == '0)
            else $error("single result has low fraction bits set");
      end
   end

   assert_quiet_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_flag_update |-> !out_frac_inexact && !out_frac_rounded);

   assert_rounded_inexact_R4: assert property (@(posedge clk) disable iff (!rst_n)
      out_frac_rounded |-> out_frac_inexact);

   assert_sticky_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_inexact_sticky |=> out_inexact_sticky);

   assert_sticky_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_frac_inexact |-> out_inexact_sticky);

   assert_zero_class_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_class == CLS_POS_ZERO |-> out_result == '0);

   assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> out_valid == $past(in_valid));

   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_result) && $stable(out_class));

endmodule

// File: tb/tb_int2fp_conv.sv
`timescale 1ns/1ps
module tb_int2fp_conv;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [63:0] in_operand = '0;
   logic [1:0]  in_int_type = '0;
   logic        in_single = 1'b0;
   logic [1:0]  in_rmode = '0;
   logic        out_valid;
   logic [63:0] out_result;
   logic [4:0]  out_class;
   logic        out_frac_rounded;
   logic        out_frac_inexact;
   logic        out_inexact_sticky;
   logic        out_flag_update;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   int2fp_conv dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_operand(in_operand),
      .in_int_type(in_int_type), .in_single(in_single), .in_rmode(in_rmode),
      .out_valid(out_valid), .out_result(out_result), .out_class(out_class),
      .out_frac_rounded(out_frac_rounded), .out_frac_inexact(out_frac_inexact),
      .out_inexact_sticky(out_inexact_sticky), .out_flag_update(out_flag_update)
   );

   // {operand, type, single, rmode, result, class, flag_update, rounded, inexact, sticky}
   localparam int NV = 19;
   localparam logic [141:0] VEC [NV] = '{
      // R1 signed 32-bit one to double, exact, quiet (R2)
      {64'h0000_0000_0000_0001, 2'd0, 1'b0, 2'd0, 64'h3FF0_0000_0000_0000, 5'b00100, 1'b0, 1'b0, 1'b0, 1'b0},
      // R1 upper bits ignored, -1 as signed 32-bit
      {64'hDEAD_BEEF_FFFF_FFFF, 2'd0, 1'b0, 2'd0, 64'hBFF0_0000_0000_0000, 5'b01000, 1'b0, 1'b0, 1'b0, 1'b0},
      // R1 unsigned 32-bit max to double
      {64'h0000_0000_FFFF_FFFF, 2'd1, 1'b0, 2'd0, 64'h41EF_FFFF_FFE0_0000, 5'b00100, 1'b0, 1'b0, 1'b0, 1'b0},
      // R1 signed 32-bit minimum
      {64'h0000_0000_8000_0000, 2'd0, 1'b0, 2'd0, 64'hC1E0_0000_0000_0000, 5'b01000, 1'b0, 1'b0, 1'b0, 1'b0},
      // R2 mode ignored on exact path
      {64'h0000_0000_0000_0005, 2'd0, 1'b0, 2'd1, 64'h4014_0000_0000_0000, 5'b00100, 1'b0, 1'b0, 1'b0, 1'b0},
      // R8 zero, double, toward minus infinity
      {64'h0000_0000_0000_0000, 2'd2, 1'b0, 2'd3, 64'h0000_0000_0000_0000, 5'b00010, 1'b1, 1'b0, 1'b0, 1'b0},
      // R8 zero, single, toward plus infinity
      {64'h0000_0000_0000_0000, 2'd3, 1'b1, 2'd2, 64'h0000_0000_0000_0000, 5'b00010, 1'b1, 1'b0, 1'b0, 1'b0},
      // R6 exact single conversion updates flags
      {64'h0000_0000_0000_0003, 2'd1, 1'b1, 2'd0, 64'h4008_0000_0000_0000, 5'b00100, 1'b1, 1'b0, 1'b0, 1'b0},
      // R9 u64 all ones nearest -> 2^64, carry into exponent
      {64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 1'b0, 2'd0, 64'h43F0_0000_0000_0000, 5'b00100, 1'b1, 1'b1, 1'b1, 1'b1},
      // R9 u64 all ones toward zero
      {64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 1'b0, 2'd1, 64'h43EF_FFFF_FFFF_FFFF, 5'b00100, 1'b1, 1'b0, 1'b1, 1'b1},
      // R9 s64 minimum exact
      {64'h8000_0000_0000_0000, 2'd2, 1'b0, 2'd0, 64'hC3E0_0000_0000_0000, 5'b01000, 1'b1, 1'b0, 1'b0, 1'b1},
      // R3 single tie, even kept bit: no increment
      {64'h0000_0000_0100_0001, 2'd0, 1'b1, 2'd0, 64'h4170_0000_0000_0000, 5'b00100, 1'b1, 1'b0, 1'b1, 1'b1},
      // R3 single toward plus infinity, positive
      {64'h0000_0000_0100_0001, 2'd0, 1'b1, 2'd2, 64'h4170_0000_2000_0000, 5'b00100, 1'b1, 1'b1, 1'b1, 1'b1},
      // R3 single toward minus infinity, negative
      {64'h0000_0000_FEFF_FFFF, 2'd0, 1'b1, 2'd3, 64'hC170_0000_2000_0000, 5'b01000, 1'b1, 1'b1, 1'b1, 1'b1},
      // R3 single toward plus infinity, negative: magnitude truncated
      {64'h0000_0000_FEFF_FFFF, 2'd0, 1'b1, 2'd2, 64'hC170_0000_0000_0000, 5'b01000, 1'b1, 1'b0, 1'b1, 1'b1},
      // R3 double tie, even: stays
      {64'h0020_0000_0000_0001, 2'd2, 1'b0, 2'd0, 64'h4340_0000_0000_0000, 5'b00100, 1'b1, 1'b0, 1'b1, 1'b1},
      // R3 double tie, odd: rounds up
      {64'h0020_0000_0000_0003, 2'd2, 1'b0, 2'd0, 64'h4340_0000_0000_0002, 5'b00100, 1'b1, 1'b1, 1'b1, 1'b1},
      // R6 single u64 all ones -> 2^64
      {64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 1'b1, 2'd0, 64'h43F0_0000_0000_0000, 5'b00100, 1'b1, 1'b1, 1'b1, 1'b1},
      // R1 s64 minus one
      {64'hFFFF_FFFF_FFFF_FFFF, 2'd2, 1'b0, 2'd0, 64'hBFF0_0000_0000_0000, 5'b01000, 1'b1, 1'b0, 1'b0, 1'b1}
   };

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic apply(input logic [141:0] v);
      @(negedge clk);
      in_operand  = v[141:78];
      in_int_type = v[77:76];
      in_single   = v[75];
      in_rmode    = v[74:73];
      in_valid    = 1'b1;
      @(negedge clk);
      in_valid    = 1'b0;
      chk("R10", "valid",   64'(out_valid), 64'd1);
      chk(v[75] ? "R6" : "R3", "result", out_result, v[72:9]);
      chk("R7",  "class",   64'(out_class), 64'(v[8:4]));
      chk("R2",  "update",  64'(out_flag_update), 64'(v[3]));
      chk("R4",  "rounded", 64'(out_frac_rounded), 64'(v[2]));
      chk("R4",  "inexact", 64'(out_frac_inexact), 64'(v[1]));
      chk("R5",  "sticky",  64'(out_inexact_sticky), 64'(v[0]));
   endtask

   task automatic summary;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11", "valid",  64'(out_valid), 64'd0);
      chk("R11", "result", out_result, 64'd0);
      chk("R11", "class",  64'(out_class), 64'd0);
      chk("R11", "sticky", 64'(out_inexact_sticky), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) apply(VEC[i]);

      // R10 no strobe: outputs hold, valid low
      in_operand = 64'h1234; in_int_type = 2'd3; in_valid = 1'b0;
      @(negedge clk);
      chk("R10", "valid low", 64'(out_valid), 64'd0);
      chk("R10", "hold",      out_result, 64'hBFF0_0000_0000_0000);

      // R11 reset clears the sticky flag mid-run
      rst_n = 1'b0;
      @(negedge clk);
      chk("R11", "sticky", 64'(out_inexact_sticky), 64'd0);
      chk("R11", "result", out_result, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      // R5 exact conversions after reset leave sticky clear; R2 quiet path
      apply(VEC[7]);
      apply(VEC[4]);
      // R5 one inexact conversion sets it, later exact ones keep it
      apply({64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 1'b0, 2'd1, 64'h43EF_FFFF_FFFF_FFFF, 5'b00100, 1'b1, 1'b0, 1'b1, 1'b1});
      apply({64'h0000_0000_0000_0001, 2'd0, 1'b0, 2'd0, 64'h3FF0_0000_0000_0000, 5'b00100, 1'b0, 1'b0, 1'b0, 1'b1});

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

endmodule